// File: doc/BRIEF.md
# Indirect Masked Memory Access Controller

This block gives a host command-driven access to an internal store of 64-bit words, each carrying a validity flag. The host presents a 12-bit opcode, a write strobe (active low: low writes, high reads), a half-select bit and a 32-bit data value. An internal pointer register names the word to touch. Every recognised access steps the pointer by one, either up or down, so a run of commands walks through the store without the host having to resend addresses.

Writes go through a bit-level merge. The opcode names one of eight mask registers. In a mask, a 0 bit lets the new data through and a 1 bit keeps the stored bit. Mask 0 is fixed at all zeros, so selecting it means an unmasked write. Masks 1 to 7 are loaded through their own port. The half-select bit decides which 32-bit half of both the word and the mask takes part in the access. On a read, the chosen half and the word's validity appear combinationally in the same cycle. The data bus is split into input, output and output-enable signals. The pointer can also be loaded directly.

Top module: `ima_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the pointer is 0, every word reads as 0 with its validity line high (empty), and masks 1 to 7 are all zeros.
- R2: A command is recognised when cmd_en is high and cmd_op[5:0] is 6'b100110 (step up) or 6'b100111 (step down). With wr_n low it writes the word at the pointer. The pointer then moves one place in the chosen direction at that clock edge.
- R3: A recognised command with wr_n high is a read. In the same cycle dq_oe is 1, dq_out carries the selected half of the word at the pointer, and vld_n_out carries the inverse of that word's validity flag. The pointer then steps as in R2.
- R4: dq_oe is 0 and vld_n_out is 1 whenever no read is being issued: cmd_en low, a write, or an unrecognised code.
- R5: cmd_op[8:6] selects the mask register used by a write. cmd_op[11:9] has no effect.
- R6: In a write, each stored bit whose mask bit is 0 takes the corresponding data bit. Each stored bit whose mask bit is 1 keeps its old value.
- R7: half_hi low selects bits 31:0 of the word and of the mask. half_hi high selects bits 63:32. The other half of the word is left unchanged.
- R8: A write loads the word's validity flag from vld_n_in. Low marks the word valid, and it then reads back with vld_n_out low. High marks it empty.
- R9: When cmd_en is low, or cmd_op[5:0] is neither code of R2, the store and the pointer are unchanged.
- R10: When addr_ld is high at a clock edge, the pointer takes addr_ld_val. This has priority over the step. A command in the same cycle still acts on the old pointer.
- R11: When mask_we is high, the mask register named by mask_sel takes mask_wdata at the clock edge. mask_sel 0 is ignored, and mask 0 always stays zero.
- R12: The pointer wraps modulo DEPTH. It goes from DEPTH-1 up to 0, and from 0 down to DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_en | input | 1 | Command present this cycle |
| cmd_op | input | 12 | Opcode: [5:0] access code, [8:6] mask select |
| wr_n | input | 1 | Low: write, high: read |
| half_hi | input | 1 | Half select: 0 = bits 31:0, 1 = bits 63:32 |
| vld_n_in | input | 1 | Validity for writes, low = valid |
| dq_in | input | 32 | Write data |
| dq_out | output | 32 | Read data |
| dq_oe | output | 1 | Read data drive enable |
| vld_n_out | output | 1 | Validity of the read word, low = valid |
| addr_ld | input | 1 | Load the pointer |
| addr_ld_val | input | 6 | Pointer load value (clog2 of DEPTH bits) |
| mask_we | input | 1 | Mask register write enable |
| mask_sel | input | 3 | Mask register to write |
| mask_wdata | input | 64 | Mask register write value |

## Verification
The hardest case to reach is a masked partial-half write whose effect is visible only on later reads. Seeing it needs a known background in both halves, a loaded mask with mixed bits, and a read of the other half to prove that half kept its value. The bench first fills every word in both halves with arithmetic patterns, sweeping the pointer upward through the wrap. It then reads the store back in the downward direction. After that it performs a masked write with each mask register in each half at its own address, reloading the pointer before each read-back. A command issued together with a pointer load tests the priority rule of R10.

// File: rtl/ima_pkg.sv
// Package: shared constants and types for the indirect masked access controller.
// Assumes the opcode layout is fixed: access code in [5:0], mask id in [8:6].
package ima_pkg;
    localparam int OP_W      = 12;
    localparam int MASK_ID_W = 3;
    localparam logic [5:0] CODE_UP = 6'b100110;
    localparam logic [5:0] CODE_DN = 6'b100111;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/ima_decode.sv
// Module: opcode decoder. Turns enable, opcode and write strobe into an
// access kind, a step direction and a mask id. Purely combinational.
// Assumes: unknown access codes are treated as no access at all.
module ima_decode
    import ima_pkg::*;
(
    input  logic                 cmd_en,
    input  logic [OP_W-1:0]      cmd_op,
    input  logic                 wr_n,
    output acc_kind_e            kind,
    output logic                 step_dn,
    output logic [MASK_ID_W-1:0] mask_id
);
    logic [5:0] code;
    logic       known;
    logic       unused_hi;

    // Classify the command and pull out its fields.
    always_comb begin
        code      = cmd_op[5:0];
        known     = (code == CODE_UP) || (code == CODE_DN);
        step_dn   = code[0];
        mask_id   = cmd_op[8:6];
        unused_hi = ^cmd_op[OP_W-1:9];
        if (!(cmd_en && known)) begin
            kind = ACC_IDLE;
        end else if (wr_n) begin
            kind = ACC_READ;
        end else begin
            kind = ACC_WRITE;
        end
    end
endmodule

// File: rtl/ima_mask_bank.sv
// Module: bank of mask registers with one write port and one read port.
// Register 0 is constant zero; the others reset to zero.
// Assumes: a write to index 0 is silently dropped.
module ima_mask_bank #(
    parameter  int DW    = 64,
    parameter  int NMASK = 8,
    localparam int SW    = $clog2(NMASK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [SW-1:0] rd_sel,
    output logic [DW-1:0] rd_mask
);
    logic [DW-1:0] bank [NMASK];

    for (genvar g = 0; g < NMASK; g++) begin : g_mask
        if (g == 0) begin : g_zero
            assign bank[g] = '0;
        end else begin : g_reg
            logic [DW-1:0] r_q;
            // Hold one mask register, loaded when its index is written.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    r_q <= '0;
                end else if (wr_en && (wr_sel == SW'(g))) begin
                    r_q <= wr_data;
                end
            end
            assign bank[g] = r_q;
        end
    end

    // Select the mask named by the current command.
    always_comb begin
        rd_mask = bank[rd_sel];
    end
endmodule

// File: rtl/ima_addr_reg.sv
// Module: pointer register. It loads directly or steps by one with wrap
// modulo DEPTH. A direct load has priority over a step.
// Assumes: ld_val is below DEPTH.
module ima_addr_reg #(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          step,
    input  logic          step_dn,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] addr_up;
    logic [AW-1:0] addr_dn;

    // Neighbour addresses with wrap at both ends.
    always_comb begin
        addr_up = (addr == LAST) ? '0 : addr + 1'b1;
        addr_dn = (addr == '0) ? LAST : addr - 1'b1;
    end

    // Update the pointer: reset, load, or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (ld) begin
            addr <= ld_val;
        end else if (step) begin
            addr <= step_dn ? addr_dn : addr_up;
        end
    end
endmodule

// File: rtl/ima_store.sv
// Module: word store with a validity flag per word. It writes one half of a
// word through a bit mask (1 keeps the old bit) and reads one half
// combinationally.
// Assumes: addr is below DEPTH; all words and flags reset to zero.
module ima_store #(
    parameter  int DEPTH = 64,
    parameter  int HW    = 32,
    localparam int DW    = 2 * HW,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic          half_hi,
    input  logic [HW-1:0] wr_data,
    input  logic [DW-1:0] wr_mask,
    input  logic          wr_valid,
    output logic [HW-1:0] rd_data,
    output logic          rd_valid
);
    logic [DW-1:0] words [DEPTH];
    logic          flags [DEPTH];
    logic [DW-1:0] cur;
    logic [HW-1:0] old_half;
    logic [HW-1:0] mask_half;
    logic [HW-1:0] merged;
    logic [DW-1:0] new_word;

    // Build the merged word for a write to the current location.
    always_comb begin
        cur       = words[addr];
        old_half  = half_hi ? cur[DW-1:HW] : cur[HW-1:0];
        mask_half = half_hi ? wr_mask[DW-1:HW] : wr_mask[HW-1:0];
        merged    = (old_half & mask_half) | (wr_data & ~mask_half);
        new_word  = half_hi ? {merged, cur[HW-1:0]} : {cur[DW-1:HW], merged};
        rd_data   = old_half;
        rd_valid  = flags[addr];
    end

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [DW-1:0] word_q;
        logic          flag_q;
        // Hold one word and its flag, written when the pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
                flag_q <= 1'b0;
            end else if (wr_en && (addr == AW'(w))) begin
                word_q <= new_word;
                flag_q <= wr_valid;
            end
        end
        assign words[w] = word_q;
        assign flags[w] = flag_q;
    end
endmodule

// File: rtl/ima_ctrl.sv
// Module: top of the indirect masked memory access controller. It joins the
// decoder, mask bank, pointer register and store, and drives the split data
// bus.
// Assumes: one command per cycle. A command acts on the pointer value held
// before the edge.
module ima_ctrl
    import ima_pkg::*;
#(
    parameter  int DEPTH  = 64,
    parameter  int HALF_W = 32,
    localparam int AW     = $clog2(DEPTH),
    localparam int DW     = 2 * HALF_W,
    localparam int NMASK  = 2 ** MASK_ID_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_en,
    input  logic [OP_W-1:0]      cmd_op,
    input  logic                 wr_n,
    input  logic                 half_hi,
    input  logic                 vld_n_in,
    input  logic [HALF_W-1:0]    dq_in,
    output logic [HALF_W-1:0]    dq_out,
    output logic                 dq_oe,
    output logic                 vld_n_out,
    input  logic                 addr_ld,
    input  logic [AW-1:0]        addr_ld_val,
    input  logic                 mask_we,
    input  logic [MASK_ID_W-1:0] mask_sel,
    input  logic [DW-1:0]        mask_wdata
);
    acc_kind_e              kind;
    logic                   step_dn;
    logic [MASK_ID_W-1:0]   mask_id;
    logic [DW-1:0]          sel_mask;
    logic [AW-1:0]          cur_addr;
    logic [HALF_W-1:0]      rd_data;
    logic                   rd_valid;
    logic                   is_read;
    logic                   is_write;

    ima_decode u_dec (
        .cmd_en  (cmd_en),
        .cmd_op  (cmd_op),
        .wr_n    (wr_n),
        .kind    (kind),
        .step_dn (step_dn),
        .mask_id (mask_id)
    );

    ima_mask_bank #(.DW(DW), .NMASK(NMASK)) u_masks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_we),
        .wr_sel  (mask_sel),
        .wr_data (mask_wdata),
        .rd_sel  (mask_id),
        .rd_mask (sel_mask)
    );

    ima_addr_reg #(.DEPTH(DEPTH)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (addr_ld),
        .ld_val  (addr_ld_val),
        .step    (is_read || is_write),
        .step_dn (step_dn),
        .addr    (cur_addr)
    );

    ima_store #(.DEPTH(DEPTH), .HW(HALF_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (is_write),
        .addr     (cur_addr),
        .half_hi  (half_hi),
        .wr_data  (dq_in),
        .wr_mask  (sel_mask),
        .wr_valid (~vld_n_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Drive the read side of the bus only while a read is issued.
    always_comb begin
        is_read   = (kind == ACC_READ);
        is_write  = (kind == ACC_WRITE);
        dq_oe     = is_read;
        dq_out    = is_read ? rd_data : '0;
        vld_n_out = is_read ? ~rd_valid : 1'b1;
    end
endmodule

// File: rtl/ima_ctrl_chk.sv
// Module: assertion checker for ima_ctrl, attached by bind. It watches the
// command ports, bus outputs and pointer.
// Assumes: the same DEPTH as the bound instance.
module ima_ctrl_chk #(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_en,
    input logic [11:0]   cmd_op,
    input logic          wr_n,
    input logic          addr_ld,
    input logic [AW-1:0] addr_ld_val,
    input logic          dq_oe,
    input logic          vld_n_out,
    input logic [AW-1:0] cur_addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    logic is_up;
    logic is_dn;
    assign is_up = cmd_en && (cmd_op[5:0] == 6'b100110);
    assign is_dn = cmd_en && (cmd_op[5:0] == 6'b100111);

    p_reset_ptr_r1: assert property (@(posedge clk)
        !rst_n |=> (cur_addr == '0));

    p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_up && !addr_ld) |=>
        (cur_addr == (($past(cur_addr) == LAST) ? '0 : $past(cur_addr) + 1'b1)));

    p_step_dn_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dn && !addr_ld) |=>
        (cur_addr == (($past(cur_addr) == '0) ? LAST : $past(cur_addr) - 1'b1)));

    p_oe_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_up || is_dn) && wr_n |-> dq_oe);

    p_oe_only_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (cmd_en && wr_n));

    p_vld_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> vld_n_out);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_ld && !is_up && !is_dn) |=> $stable(cur_addr));

    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ld |=> (cur_addr == $past(addr_ld_val)));
endmodule

bind ima_ctrl ima_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_en      (cmd_en),
    .cmd_op      (cmd_op),
    .wr_n        (wr_n),
    .addr_ld     (addr_ld),
    .addr_ld_val (addr_ld_val),
    .dq_oe       (dq_oe),
    .vld_n_out   (vld_n_out),
    .cur_addr    (cur_addr)
);

// File: tb/ima_ctrl_bench.sv
`timescale 1ns/1ps
// Bench for ima_ctrl: a reference model of store, masks and pointer built
// from the requirements, driven by sweeps and directed corner cases.
module ima_ctrl_bench;
    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam logic [11:0] OP_UP = 12'b000_000_100110;
    localparam logic [11:0] OP_DN = 12'b000_000_100111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_en = 1'b0;
    logic [11:0] cmd_op = '0;
    logic        wr_n = 1'b1;
    logic        half_hi = 1'b0;
    logic        vld_n_in = 1'b1;
    logic [31:0] dq_in = '0;
    logic [31:0] dq_out;
    logic        dq_oe;
    logic        vld_n_out;
    logic        addr_ld = 1'b0;
    logic [AW-1:0] addr_ld_val = '0;
    logic        mask_we = 1'b0;
    logic [2:0]  mask_sel = '0;
    logic [63:0] mask_wdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0]   m_mem  [DEPTH];
    logic          m_vld  [DEPTH];
    logic [63:0]   m_mask [8];
    logic [AW-1:0] m_addr;

    always #2.5 clk = ~clk;

    ima_ctrl u_ima_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_op(cmd_op), .wr_n(wr_n),
        .half_hi(half_hi), .vld_n_in(vld_n_in), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .vld_n_out(vld_n_out), .addr_ld(addr_ld),
        .addr_ld_val(addr_ld_val), .mask_we(mask_we), .mask_sel(mask_sel),
        .mask_wdata(mask_wdata)
    );

    function automatic logic [31:0] pat(input int a, input int h);
        return (32'h9E37_79B1 * (a + 1)) ^ (h != 0 ? 32'hA5A5_0F0F : 32'h0);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One command cycle: drive at the falling edge, check the combinational
    // outputs, update the model at the rising edge, then release.
    task automatic cmd(input bit en, input logic [11:0] op, input logic wn,
                       input logic hh, input logic vn, input logic [31:0] d,
                       input bit ld, input logic [AW-1:0] ldv, input string req);
        bit known;
        bit rd;
        logic [31:0] exp_d;
        logic [31:0] mh;
        logic [31:0] oh;
        logic [31:0] nh;
        @(negedge clk);
        cmd_en = en; cmd_op = op; wr_n = wn; half_hi = hh; vld_n_in = vn;
        dq_in = d; addr_ld = ld; addr_ld_val = ldv;
        #1;
        known = en && (op[5:0] == 6'b100110 || op[5:0] == 6'b100111);
        rd = known && wn;
        if (rd) begin
            exp_d = hh ? m_mem[m_addr][63:32] : m_mem[m_addr][31:0];
            check(dq_oe === 1'b1 && dq_out === exp_d && vld_n_out === ~m_vld[m_addr],
                  req, "read data/oe/vld",
                  {30'd0, dq_oe, vld_n_out, dq_out}, {30'd0, 1'b1, ~m_vld[m_addr], exp_d});
        end else begin
            check(dq_oe === 1'b0 && vld_n_out === 1'b1, "R4", "idle oe/vld",
                  {62'd0, dq_oe, vld_n_out}, 64'd1);
        end
        @(posedge clk);
        if (known && !wn) begin
            mh = hh ? m_mask[op[8:6]][63:32] : m_mask[op[8:6]][31:0];
            oh = hh ? m_mem[m_addr][63:32] : m_mem[m_addr][31:0];
            nh = (oh & mh) | (d & ~mh);
            if (hh) m_mem[m_addr][63:32] = nh;
            else    m_mem[m_addr][31:0]  = nh;
            m_vld[m_addr] = ~vn;
        end
        if (ld) begin
            m_addr = ldv;
        end else if (known) begin
            if (op[0]) m_addr = (m_addr == 0) ? AW'(DEPTH - 1) : m_addr - 1'b1;
            else       m_addr = (m_addr == AW'(DEPTH - 1)) ? '0 : m_addr + 1'b1;
        end
        #1;
        cmd_en = 1'b0; addr_ld = 1'b0;
    endtask

    task automatic load_ptr(input logic [AW-1:0] v);
        cmd(1'b0, 12'h000, 1'b1, 1'b0, 1'b1, 32'h0, 1'b1, v, "R10");
    endtask

    task automatic write_mask(input logic [2:0] s, input logic [63:0] v);
        @(negedge clk);
        mask_we = 1'b1; mask_sel = s; mask_wdata = v;
        @(posedge clk);
        if (s != 0) m_mask[s] = v;
        #1;
        mask_we = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_vld[i] = 1'b0; end
        for (int i = 0; i < 8; i++) m_mask[i] = '0;
        m_addr = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, read the first few words in both halves
        for (int i = 0; i < 4; i++)
            cmd(1'b1, OP_UP, 1'b1, i[0], 1'b1, 32'h0, 1'b0, '0, "R1");

        // R2 R7 R8 R12: fill low halves then high halves, stepping up through the wrap
        load_ptr('0);
        for (int h = 0; h < 2; h++)
            for (int a = 0; a < DEPTH; a++)
                cmd(1'b1, OP_UP, 1'b0, h[0], 1'b0, pat(a, h), 1'b0, '0, "R2");

        // R3 R12: read everything back stepping down from the top, wrapping
        load_ptr(AW'(DEPTH - 1));
        for (int h = 0; h < 2; h++)
            for (int a = 0; a < DEPTH; a++)
                cmd(1'b1, OP_DN, 1'b1, h[0], 1'b1, 32'h0, 1'b0, '0, "R3");

        // R11: load masks; an attempt on mask 0 must leave it at zero
        for (int k = 1; k < 8; k++)
            write_mask(k[2:0], {32'h0F0F_3C3C ^ (32'h1111_1111 * k),
                                32'hF0F0_5A5A ^ (32'h0101_0101 * k)});
        write_mask(3'd0, {64{1'b1}});

        // R5 R6 R7 R11: masked write per mask per half, then read both halves
        for (int k = 0; k < 8; k++) begin
            for (int h = 0; h < 2; h++) begin
                logic [AW-1:0] ad;
                logic [11:0] op;
                ad = AW'(8 + 2 * k + h);
                op = {3'(k + 5), 3'(k), 6'b100110};
                load_ptr(ad);
                cmd(1'b1, op, 1'b0, h[0], 1'b0, 32'hFFFF_FFFF ^ (32'h1357 * k),
                    1'b0, '0, "R6");
                load_ptr(ad);
                cmd(1'b1, OP_UP, 1'b1, 1'b0, 1'b1, 32'h0, 1'b0, '0, "R6");
                load_ptr(ad);
                cmd(1'b1, OP_UP, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, '0, "R7");
            end
        end

        // R8: a write with vld_n_in high marks the word empty
        load_ptr(6'd5);
        cmd(1'b1, OP_DN, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF, 1'b0, '0, "R8");
        load_ptr(6'd5);
        cmd(1'b1, OP_DN, 1'b1, 1'b0, 1'b1, 32'h0, 1'b0, '0, "R8");
        cmd(1'b1, OP_DN, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, '0, "R8");

        // R9: unrecognised codes and cmd_en low change neither store nor pointer
        load_ptr(6'd20);
        cmd(1'b1, 12'b000_000_000010, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 1'b0, '0, "R9");
        cmd(1'b1, 12'b000_000_100100, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 1'b0, '0, "R9");
        cmd(1'b1, 12'b000_000_111111, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, '0, "R9");
        cmd(1'b0, OP_UP, 1'b0, 1'b0, 1'b0, 32'hCAFE_F00D, 1'b0, '0, "R9");
        cmd(1'b1, OP_UP, 1'b1, 1'b0, 1'b1, 32'h0, 1'b0, '0, "R9");

        // R10: command with a simultaneous load acts on the old pointer
        load_ptr(6'd30);
        cmd(1'b1, OP_UP, 1'b0, 1'b1, 1'b0, 32'h0BAD_F00D, 1'b1, 6'd40, "R10");
        cmd(1'b1, OP_UP, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, '0, "R10");
        load_ptr(6'd30);
        cmd(1'b1, OP_UP, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, '0, "R10");

        // R12: step up from the top wraps to 0
        load_ptr(AW'(DEPTH - 1));
        cmd(1'b1, OP_UP, 1'b0, 1'b0, 1'b0, 32'h7777_0001, 1'b0, '0, "R12");
        cmd(1'b1, OP_DN, 1'b1, 1'b0, 1'b1, 32'h0, 1'b0, '0, "R12");
        cmd(1'b1, OP_DN, 1'b1, 1'b0, 1'b1, 32'h0, 1'b0, '0, "R12");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule